// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Unit

This block samples a vector of general-purpose input pins, keeps the captured level of each pin in a port data word, and decides for every pin whether its behaviour should raise an interrupt. Each bit has its own set of controls. A direction bit and an input-enable bit admit the pin. A sense-mode bit selects edge or level sensing. A dual-edge bit makes any edge count. A polarity bit selects the active edge or the active level.

A pin event that qualifies is routed to two separate interrupt requests, A and B. Each request has its own mask word, so one event can reach one line, both lines or neither. The pins pass through a two-flop synchronizer before any comparison. An edge event gives a single-cycle pulse. A level-sensitive pin holds its request high for as long as it stays active and unmasked. The port word has one more bit than there are pins. The top bit has no pin, so it stays at zero and never interrupts.

Top module: `gpio_sense_unit`

## Requirements
- R1: A data bit loads the synchronized pin level only while both its direction bit and its input-enable bit are 1. Otherwise the bit holds its value and the pin raises no interrupt.
- R2: A pin change applied before clock edge k appears on `data_o` and on the interrupt outputs after edge k+2, because of two synchronizer flops and one output register.
- R3: With sense-mode 1 and dual-edge 1, both a rising and a falling change raise an event. That event is a pulse on the interrupt output lasting exactly one cycle.
- R4: With sense-mode 1 and dual-edge 0, polarity 0 qualifies only low-to-high changes and polarity 1 qualifies only high-to-low changes.
- R5: With sense-mode 0, the pin is active while its level differs from its polarity bit. Polarity 0 is therefore active-high and polarity 1 active-low. The request stays high for as long as the pin is active.
- R6: `irq_a_o` is the registered OR of the events whose bit is set in `mask_a_i`, and `irq_b_o` likewise uses `mask_b_i`. One event can drive both outputs.
- R7: The top bit of `data_o` has no pin. It stays 0 and raises no interrupt, whatever its control and mask bits are.
- R8: After synchronous reset, `data_o`, `irq_a_o` and `irq_b_o` are all 0.

Each control word has one bit per port bit: bit i configures pin i. Every control bit is active-high as described above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 15 | Asynchronous pin levels |
| dir_i | input | 16 | Per-bit direction (1 = input) |
| inen_i | input | 16 | Per-bit input enable |
| sense_edge_i | input | 16 | Per-bit sense mode (1 = edge, 0 = level) |
| dual_edge_i | input | 16 | Per-bit both-edge select |
| polar_i | input | 16 | Per-bit polarity |
| mask_a_i | input | 16 | Enables for interrupt A |
| mask_b_i | input | 16 | Enables for interrupt B |
| data_o | output | 16 | Captured port data |
| irq_a_o | output | 1 | Interrupt request A |
| irq_b_o | output | 1 | Interrupt request B |

## Verification
The assertions assume that the control words and masks come from a register bank and stay static between writes. The R6 properties compare the output against the mask of the previous cycle, so they need the masks to be synchronous to `clk`. The bench follows this rule: it changes controls and masks only at quiet points, after clearing all enables and waiting for the pipeline to drain. It changes pin levels only half a cycle away from the active edge, and it holds each level for several cycles. This keeps every edge a single clean transition, which is what the edge-change property expects.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

    localparam int unsigned PORT_W_DEF = 16;
    localparam int unsigned PIN_N_DEF  = 15;

    typedef struct packed {
        logic dir;
        logic inen;
        logic sense_edge;
        logic dual_edge;
        logic polar;
    } pin_cfg_t;

    typedef struct packed {
        logic a;
        logic b;
    } irq_pair_t;

    // Decide whether a transition old_lvl -> new_lvl qualifies under cfg
    function automatic logic qualify(pin_cfg_t cfg, logic old_lvl, logic new_lvl);
        logic hit;
        if (cfg.sense_edge) begin
            if (cfg.dual_edge)
                hit = (old_lvl != new_lvl);
            else if (cfg.polar)
                hit = old_lvl & ~new_lvl;
            else
                hit = ~old_lvl & new_lvl;
        end else begin
            hit = (new_lvl != cfg.polar);
        end
        return hit;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_sense_cell.sv
module gpio_sense_cell
    import gpio_sense_pkg::*;
#(
    parameter bit HAS_PIN = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     pin_s,
    output logic     data_q,
    output logic     evt
);
    logic en;

    assign en = HAS_PIN && cfg.dir && cfg.inen;

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= 1'b0;
        else if (en)
            data_q <= pin_s;
    end

    assign evt = en && qualify(cfg, data_q, pin_s);

    // R1: a disabled bit keeps its captured level
    assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (data_q == $past(data_q)));

    // R3: an edge event always coincides with a real level change
    assert_edge_needs_change_R3: assert property (@(posedge clk) disable iff (rst)
        (evt && cfg.sense_edge) |-> (pin_s != data_q));

    // R4: single-edge events land on the level opposite the polarity bit
    assert_single_edge_dir_R4: assert property (@(posedge clk) disable iff (rst)
        (evt && cfg.sense_edge && !cfg.dual_edge) |-> (pin_s == !cfg.polar));

    // R5: a level pin sitting at its polarity level is idle
    assert_level_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !cfg.sense_edge && (pin_s == cfg.polar)) |-> !evt);
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_sense_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_vec,
    input  logic [W-1:0] mask_a,
    input  logic [W-1:0] mask_b,
    output irq_pair_t    irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q.a <= |(evt_vec & mask_a);
            irq_q.b <= |(evt_vec & mask_b);
        end
    end

    // R6: a line with an all-zero mask stays quiet next cycle
    assert_mask_a_gates_R6: assert property (@(posedge clk) disable iff (rst)
        (mask_a == '0) |=> !irq_q.a);
    assert_mask_b_gates_R6: assert property (@(posedge clk) disable iff (rst)
        (mask_b == '0) |=> !irq_q.b);
endmodule

// File: rtl/gpio_sense_unit.sv
module gpio_sense_unit
    import gpio_sense_pkg::*;
#(
    parameter int unsigned PORT_W = PORT_W_DEF,
    parameter int unsigned PIN_N  = PIN_N_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_N-1:0]  pin_i,
    input  logic [PORT_W-1:0] dir_i,
    input  logic [PORT_W-1:0] inen_i,
    input  logic [PORT_W-1:0] sense_edge_i,
    input  logic [PORT_W-1:0] dual_edge_i,
    input  logic [PORT_W-1:0] polar_i,
    input  logic [PORT_W-1:0] mask_a_i,
    input  logic [PORT_W-1:0] mask_b_i,
    output logic [PORT_W-1:0] data_o,
    output logic              irq_a_o,
    output logic              irq_b_o
);
    logic [PIN_N-1:0]  pin_s;
    logic [PORT_W-1:0] evt_vec;
    irq_pair_t         irq_q;

    gpio_pin_sync #(.W(PIN_N)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_i),
        .sync_o  (pin_s)
    );

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        pin_cfg_t cfg;
        assign cfg = '{dir:        dir_i[i],
                       inen:       inen_i[i],
                       sense_edge: sense_edge_i[i],
                       dual_edge:  dual_edge_i[i],
                       polar:      polar_i[i]};
        if (i < PIN_N) begin : g_pin
            gpio_sense_cell #(.HAS_PIN(1'b1)) u_cell (
                .clk    (clk),
                .rst    (rst),
                .cfg    (cfg),
                .pin_s  (pin_s[i]),
                .data_q (data_o[i]),
                .evt    (evt_vec[i])
            );
        end else begin : g_pad
            gpio_sense_cell #(.HAS_PIN(1'b0)) u_cell (
                .clk    (clk),
                .rst    (rst),
                .cfg    (cfg),
                .pin_s  (1'b0),
                .data_q (data_o[i]),
                .evt    (evt_vec[i])
            );
        end
    end

    gpio_irq_route #(.W(PORT_W)) u_route (
        .clk     (clk),
        .rst     (rst),
        .evt_vec (evt_vec),
        .mask_a  (mask_a_i),
        .mask_b  (mask_b_i),
        .irq_q   (irq_q)
    );

    assign irq_a_o = irq_q.a;
    assign irq_b_o = irq_q.b;

    // R7: the pin-less top bit never captures a one
    assert_top_bit_zero_R7: assert property (@(posedge clk) disable iff (rst)
        data_o[PORT_W-1] == 1'b0);
endmodule

// File: tb/gpio_sense_unit_tb.sv
module gpio_sense_unit_tb;
    localparam int PW = 16;
    localparam int PN = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PN-1:0] pin_i = '0;
    logic [PW-1:0] dir_i = '0, inen_i = '0, sense_edge_i = '0, dual_edge_i = '0;
    logic [PW-1:0] polar_i = '0, mask_a_i = '0, mask_b_i = '0;
    logic [PW-1:0] data_o;
    logic          irq_a_o, irq_b_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int            at;
        logic          a;
        logic          b;
        logic [PW-1:0] dmask;
        logic [PW-1:0] dval;
        string         tag;
    } exp_t;

    exp_t sb[$];

    gpio_sense_unit u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i),
        .dir_i(dir_i), .inen_i(inen_i), .sense_edge_i(sense_edge_i),
        .dual_edge_i(dual_edge_i), .polar_i(polar_i),
        .mask_a_i(mask_a_i), .mask_b_i(mask_b_i),
        .data_o(data_o), .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every scoreboard item due in the current cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                checks++;
                if (irq_a_o !== sb[i].a || irq_b_o !== sb[i].b ||
                    (data_o & sb[i].dmask) !== sb[i].dval) begin
                    errors++;
                    $display("FAIL %s: got a=%b b=%b data=%h, expected a=%b b=%b data&%h=%h",
                             sb[i].tag, irq_a_o, irq_b_o, data_o,
                             sb[i].a, sb[i].b, sb[i].dmask, sb[i].dval);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(int d, logic a, logic b, logic [PW-1:0] dm,
                             logic [PW-1:0] dv, string tag);
        exp_t e;
        e.at = cyc + d; e.a = a; e.b = b; e.dmask = dm; e.dval = dv; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic quiet();
        dir_i = '0; inen_i = '0; sense_edge_i = '0; dual_edge_i = '0;
        polar_i = '0; mask_a_i = '0; mask_b_i = '0;
        step(4);
        pin_i = '0;
        step(4);
    endtask

    task automatic cfg_pin(int p, logic se, logic de, logic pol, logic ma, logic mb);
        dir_i[p] = 1'b1; inen_i[p] = 1'b1; sense_edge_i[p] = se;
        dual_edge_i[p] = de; polar_i[p] = pol; mask_a_i[p] = ma; mask_b_i[p] = mb;
    endtask

    initial begin
        step(1);
        expect_at(1, 0, 0, 16'hFFFF, 16'h0000, "R8 reset state");
        step(3);
        rst = 1'b0;
        step(4);

        // R1: direction off, then input enable off
        mask_a_i = 16'hFFFF; mask_b_i = 16'hFFFF;
        inen_i[2] = 1'b1; sense_edge_i[2] = 1'b1; dual_edge_i[2] = 1'b1;
        step(4);
        pin_i[2] = 1'b1;
        expect_at(3, 0, 0, 16'h0004, 16'h0000, "R1 dir off ignored");
        expect_at(4, 0, 0, 16'h0004, 16'h0000, "R1 dir off ignored");
        step(6);
        dir_i[2] = 1'b1; inen_i[2] = 1'b0;
        step(2);
        pin_i[2] = 1'b0;
        expect_at(3, 0, 0, 16'h0004, 16'h0000, "R1 inen off ignored");
        step(6);
        quiet();

        // R3 and R2: both-edge on pin 0, routed to A only
        cfg_pin(0, 1, 1, 0, 1, 0);
        step(5);
        pin_i[0] = 1'b1;
        expect_at(2, 0, 0, 16'h0001, 16'h0000, "R2 not yet visible");
        expect_at(3, 1, 0, 16'h0001, 16'h0001, "R3 rise pulse");
        expect_at(4, 0, 0, 16'h0001, 16'h0001, "R3 pulse one cycle");
        step(6);
        pin_i[0] = 1'b0;
        expect_at(3, 1, 0, 16'h0001, 16'h0000, "R3 fall pulse");
        expect_at(4, 0, 0, 16'h0001, 16'h0000, "R3 fall pulse ends");
        step(6);
        quiet();

        // R4: single edge, polarity 0, on B only
        cfg_pin(1, 1, 0, 0, 0, 1);
        step(5);
        pin_i[1] = 1'b1;
        expect_at(3, 0, 1, 16'h0002, 16'h0002, "R4 pol0 rising fires");
        expect_at(4, 0, 0, 16'h0002, 16'h0002, "R4 pol0 pulse ends");
        step(6);
        pin_i[1] = 1'b0;
        expect_at(3, 0, 0, 16'h0002, 16'h0000, "R4 pol0 falling ignored");
        step(6);
        quiet();

        // R4 and R6: polarity 1, both masks
        cfg_pin(3, 1, 0, 1, 1, 1);
        step(5);
        pin_i[3] = 1'b1;
        expect_at(3, 0, 0, 16'h0008, 16'h0008, "R4 pol1 rising ignored");
        step(6);
        pin_i[3] = 1'b0;
        expect_at(3, 1, 1, 16'h0008, 16'h0000, "R6 one event both lines");
        expect_at(4, 0, 0, 16'h0008, 16'h0000, "R4 pol1 pulse ends");
        step(6);
        quiet();

        // R5: level active-high
        cfg_pin(4, 0, 0, 0, 1, 0);
        step(5);
        expect_at(0, 0, 0, 16'h0010, 16'h0000, "R5 active-high idle");
        pin_i[4] = 1'b1;
        expect_at(3, 1, 0, 16'h0010, 16'h0010, "R5 level asserts");
        expect_at(7, 1, 0, 16'h0010, 16'h0010, "R5 level held");
        step(8);
        pin_i[4] = 1'b0;
        expect_at(3, 0, 0, 16'h0010, 16'h0000, "R5 level released");
        step(6);
        quiet();

        // R5: level active-low, mask B
        cfg_pin(5, 0, 0, 1, 0, 1);
        expect_at(2, 0, 1, 16'h0020, 16'h0000, "R5 active-low low is active");
        step(5);
        pin_i[5] = 1'b1;
        expect_at(2, 0, 1, 16'h0020, 16'h0000, "R2 still old level");
        expect_at(3, 0, 0, 16'h0020, 16'h0020, "R5 active-low high idle");
        step(6);
        quiet();

        // R6: event with masks clear reaches neither line
        cfg_pin(7, 1, 1, 0, 0, 0);
        step(5);
        pin_i[7] = 1'b1;
        expect_at(3, 0, 0, 16'h0080, 16'h0080, "R6 masked event dropped");
        step(6);
        quiet();

        // R7: top bit fully configured, no pin behind it
        dir_i[15] = 1; inen_i[15] = 1; sense_edge_i[15] = 0; polar_i[15] = 1;
        mask_a_i[15] = 1; mask_b_i[15] = 1;
        expect_at(2, 0, 0, 16'h8000, 16'h0000, "R7 top bit silent");
        expect_at(5, 0, 0, 16'h8000, 16'h0000, "R7 top bit silent");
        step(6);
        quiet();

        // R1: captured bit holds after input enable is dropped
        cfg_pin(6, 0, 0, 0, 0, 0);
        step(5);
        pin_i[6] = 1'b1;
        expect_at(3, 0, 0, 16'h0040, 16'h0040, "R1 enabled capture");
        step(6);
        inen_i[6] = 1'b0;
        pin_i[6] = 1'b0;
        expect_at(3, 0, 0, 16'h0040, 16'h0040, "R1 disabled bit holds");
        expect_at(6, 0, 0, 16'h0040, 16'h0040, "R1 disabled bit holds");
        step(8);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule